// File: doc/BRIEF.md
# Keyboard-Port Wait-State Generator

This block stretches a CPU input cycle aimed at the keyboard port, so that a slow helper controller has time to put the key data on the bus. It watches the I/O request, read and lowest address line on every system clock. An input from an even port address produces an active-low keyboard strobe. The first cycle of each strobe is also given to the controller as a one-clock interrupt request.

On that same edge, a latch is armed that pulls the CPU's wait line low. The latch only arms if the controller has raised its enable input. That input stays at 0 while the controller boots, so the CPU is never held during start-up.

The controller ends the wait by raising a release input. Release clears the latch at once, without waiting for a clock. The latch cannot set again until the strobe has gone high and then fallen anew. If the controller never answers, a timeout counter frees the CPU after a fixed number of clocks. The wait output is an open-drain indication: 1 means pull the line low, 0 means let it float.

Top module: `kbd_wait_gen`

## Requirements
- R1: After reset, kbdStrobeN is 1, irqReq is 0 and waitPull is 0.
- R2: kbdStrobeN is 0 in the clock cycle after a rising clock edge at which iorqN=0, rdN=0 and addr0=0 are all sampled. It is 1 after any edge where one of them differs, so a write (rdN=1) or an odd port (addr0=1) gives no strobe.
- R3: irqReq is 1 for exactly one cycle, the first cycle in which kbdStrobeN is 0. It stays 0 while the strobe remains low.
- R4: If enable is 1 at the clock edge that ends the irqReq cycle, waitPull becomes 1 from that edge on.
- R5: If enable is 0 at that edge, waitPull stays 0, while kbdStrobeN and irqReq still behave as in R2 and R3.
- R6: When relIn is 1, waitPull is 0 immediately, without waiting for a clock edge, and it stays 0 for as long as relIn is held.
- R7: After a release, waitPull stays 0 while the strobe remains low. Wait can be set again only by a new strobe, one that follows a cycle in which kbdStrobeN was 1.
- R8: With no release, waitPull stays 1 for exactly TIMEOUT_CLKS clock cycles and then returns to 0.
- R9: If relIn is 1 at the clock edge where the wait would be set, release wins and waitPull stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| iorqN | input | 1 | CPU I/O request, active low |
| rdN | input | 1 | CPU read, active low |
| addr0 | input | 1 | Lowest CPU address bit |
| enable | input | 1 | 1 allows wait insertion; held 0 during controller boot |
| relIn | input | 1 | Active-high release from the controller, clears wait asynchronously |
| kbdStrobeN | output | 1 | Active-low keyboard-read strobe |
| irqReq | output | 1 | One-cycle interrupt request on each new strobe |
| waitPull | output | 1 | 1 = drive CPU wait line low, 0 = release it (open drain) |

## Verification
Two events can land on the same clock edge: the set of the wait latch, caused by a new strobe edge with enable high, and a release from the controller. The bench raises relIn in the same half-cycle in which it starts the port read. relIn is therefore high at the edge that would arm the latch. The result is judged correct only if waitPull never rises, both during the release and after relIn drops while the strobe is still low.

// File: rtl/kbdwait_pkg.sv
package kbdwait_pkg;
  // control -> datapath strobes
  typedef struct packed {
    logic cntRun;   // wait latch is set: advance timeout counter
    logic cntClr;   // wait latch is clear: hold counter at zero
  } ctrl_t;

  // datapath -> control status
  typedef struct packed {
    logic strobeFall;  // first low cycle of keyboard strobe
    logic timeoutHit;  // wait held for the full timeout window
  } stat_t;
endpackage

// File: rtl/kbdwait_datapath.sv
module kbdwait_datapath
  import kbdwait_pkg::*;
#(
  parameter int TIMEOUT_CLKS = 16
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  iorqN,
  input  logic  rdN,
  input  logic  addr0,
  input  ctrl_t ctrl,
  output stat_t stat,
  output logic  strobeN
);
  localparam int CNT_W = $clog2(TIMEOUT_CLKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CLKS - 1);

  logic strobePrev;
  logic [CNT_W-1:0] holdCnt;
  logic portRead;

  assign portRead = !iorqN && !rdN && !addr0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobeN    <= 1'b1;
      strobePrev <= 1'b1;
    end else begin
      strobeN    <= !portRead;
      strobePrev <= strobeN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (ctrl.cntClr || stat.timeoutHit) begin
      holdCnt <= '0;
    end else if (ctrl.cntRun) begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  assign stat.strobeFall = strobePrev && !strobeN;
  assign stat.timeoutHit = ctrl.cntRun && (holdCnt == LAST);

  // R8: counter stays inside the timeout window
  assert_cnt_in_window_R8 : assert property (@(posedge clk) disable iff (!rstN)
    holdCnt <= LAST);

  // R3: interrupt pulse never lasts two cycles
  assert_irq_single_R3 : assert property (@(posedge clk) disable iff (!rstN)
    stat.strobeFall |=> !stat.strobeFall);
endmodule

// File: rtl/kbdwait_control.sv
module kbdwait_control
  import kbdwait_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  enable,
  input  logic  relIn,
  input  stat_t stat,
  output ctrl_t ctrl,
  output logic  waitSet
);
  always_ff @(posedge clk or negedge rstN or posedge relIn) begin
    if (!rstN) begin
      waitSet <= 1'b0;
    end else if (relIn) begin
      waitSet <= 1'b0;
    end else if (stat.timeoutHit) begin
      waitSet <= 1'b0;
    end else if (stat.strobeFall && enable) begin
      waitSet <= 1'b1;
    end
  end

  assign ctrl.cntRun = waitSet;
  assign ctrl.cntClr = !waitSet;

  // R6: release keeps the latch clear
  assert_release_clears_R6 : assert property (@(posedge clk) disable iff (!rstN)
    relIn |-> !waitSet);

  // R5: no wait can start while disabled
  assert_disabled_no_wait_R5 : assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !waitSet) |=> !waitSet);

  // R4: enabled strobe edge arms the latch unless released
  assert_edge_arms_R4 : assert property (@(posedge clk) disable iff (!rstN)
    (stat.strobeFall && enable && !relIn) |=> (waitSet || relIn));

  // R7: latch rises only on a strobe edge
  assert_set_only_on_edge_R7 : assert property (@(posedge clk) disable iff (!rstN)
    (!waitSet && !stat.strobeFall) |=> !waitSet);
endmodule

// File: rtl/kbd_wait_gen.sv
module kbd_wait_gen
  import kbdwait_pkg::*;
#(
  parameter int TIMEOUT_CLKS = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic iorqN,
  input  logic rdN,
  input  logic addr0,
  input  logic enable,
  input  logic relIn,
  output logic kbdStrobeN,
  output logic irqReq,
  output logic waitPull
);
  ctrl_t ctrl;
  stat_t stat;

  kbdwait_datapath #(.TIMEOUT_CLKS(TIMEOUT_CLKS)) u_dp (
    .clk(clk), .rstN(rstN), .iorqN(iorqN), .rdN(rdN), .addr0(addr0),
    .ctrl(ctrl), .stat(stat), .strobeN(kbdStrobeN)
  );

  kbdwait_control u_ctl (
    .clk(clk), .rstN(rstN), .enable(enable), .relIn(relIn),
    .stat(stat), .ctrl(ctrl), .waitSet(waitPull)
  );

  assign irqReq = stat.strobeFall;

  // R3: interrupt only while the strobe is low
  assert_irq_with_strobe_R3 : assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> !kbdStrobeN);
endmodule

// File: tb/kbd_wait_gen_tb.sv
module kbd_wait_gen_tb;
  localparam int PERIOD = 10;
  localparam int TO = 16;

  logic clk = 0, rstN = 0, iorqN = 1, rdN = 1, addr0 = 0, enable = 0, relIn = 0;
  logic kbdStrobeN, irqReq, waitPull;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  kbd_wait_gen #(.TIMEOUT_CLKS(TO)) u_dut (
    .clk(clk), .rstN(rstN), .iorqN(iorqN), .rdN(rdN), .addr0(addr0),
    .enable(enable), .relIn(relIn), .kbdStrobeN(kbdStrobeN),
    .irqReq(irqReq), .waitPull(waitPull)
  );

  task automatic check(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idleBus();
    iorqN = 1; rdN = 1; addr0 = 0;
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic testReset();
    check("R1 strobe", kbdStrobeN, 1'b1);
    check("R1 irq", irqReq, 1'b0);
    check("R1 wait", waitPull, 1'b0);
  endtask

  task automatic testDecode();
    rdN = 1; iorqN = 0; addr0 = 0;  // write
    step(1); check("R2 write no strobe", kbdStrobeN, 1'b1);
    rdN = 0; addr0 = 1;             // odd port
    step(1); check("R2 odd no strobe", kbdStrobeN, 1'b1);
    check("R3 no irq odd", irqReq, 1'b0);
    idleBus(); step(2);
  endtask

  task automatic testDisabled();
    enable = 0;
    iorqN = 0; rdN = 0; addr0 = 0;
    step(1);
    check("R2 strobe low", kbdStrobeN, 1'b0);
    check("R3 irq pulse", irqReq, 1'b1);
    check("R5 no wait", waitPull, 1'b0);
    step(1);
    check("R3 irq ends", irqReq, 1'b0);
    check("R5 still no wait", waitPull, 1'b0);
    idleBus(); step(1);
    check("R2 strobe high", kbdStrobeN, 1'b1);
    step(1);
  endtask

  task automatic testTimeout();
    enable = 1;
    iorqN = 0; rdN = 0; addr0 = 0;
    step(1);
    check("R4 no wait yet", waitPull, 1'b0);
    step(1);
    check("R4 wait set", waitPull, 1'b1);
    for (int k = 3; k <= TO + 1; k++) begin
      step(1);
      check("R8 wait held", waitPull, 1'b1);
    end
    step(1);
    check("R8 wait timed out", waitPull, 1'b0);
    step(2);
    check("R7 no reset after timeout", waitPull, 1'b0);
    idleBus(); step(2);
  endtask

  task automatic testRelease();
    enable = 1;
    iorqN = 0; rdN = 0; addr0 = 0;
    step(2);
    check("R4 wait set", waitPull, 1'b1);
    step(2);
    relIn = 1; #1;
    check("R6 async clear", waitPull, 1'b0);
    step(3);
    check("R6 held clear", waitPull, 1'b0);
    relIn = 0;
    step(3);
    check("R7 no re-set while low", waitPull, 1'b0);
    idleBus(); step(2);
    iorqN = 0; rdN = 0;
    step(2);
    check("R7 new strobe sets", waitPull, 1'b1);
    relIn = 1; step(1); relIn = 0;
    idleBus(); step(2);
  endtask

  task automatic testCollide();
    enable = 1;
    iorqN = 0; rdN = 0; addr0 = 0; relIn = 1;
    step(1);
    check("R3 irq during release", irqReq, 1'b1);
    step(1);
    check("R9 release wins", waitPull, 1'b0);
    relIn = 0;
    step(2);
    check("R9 stays clear", waitPull, 1'b0);
    idleBus(); step(2);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(2);
    testReset();
    rstN = 1;
    step(1);
    testReset();
    testDecode();
    testDisabled();
    testTimeout();
    testRelease();
    testCollide();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule